// File: doc/BRIEF.md
# First-Error Tag Capture with Per-Class Suppression

This block keeps a record of uncorrectable and correctable error events in a set of error classes, for example single-bit ECC, double-bit ECC and data-path parity. Checkers outside the block raise a one-cycle pulse for each class, together with the 6-bit tag of the transaction in flight. For each class the block holds an 8-bit capture register. This register keeps the tag of the earliest accepted error of that class. The block also holds a system-wide pair of status vectors. The first-error vector marks the class that broke a clean state. The next-error vector marks every class that failed after that. A level interrupt stays high while either vector holds a set bit.

Software may set a suppression bit in any capture register. While that bit is set, errors of the class disappear from the system view. The tag is not stored, no status bit changes, and no interrupt follows. Instead the block asks the bus side to retire the offending transaction at once, through a combinational retire output. Software clears each capture register and status bit by writing ones. This returns the block to a clean state and arms capture again. A second error log elsewhere in the system goes on recording regardless of this suppression.

Top module: `err_first_log`

## Requirements
- R1: While reset is held, every capture register reads 0x00, both status vectors read zero, and `irq` is low.
- R2: An accepted error on class c (suppression bit 7 clear) whose capture register has valid bit 6 clear loads `err_tag` slice c into bits [5:0] and sets bit 6. Both are visible after the next rising clock edge.
- R3: Once bit 6 of a capture register is set, later errors of that class leave bits [5:0] unchanged until software clears the register.
- R4: When no first-error bit is set, the accepted errors of one cycle set the first-error bit of the lowest-numbered class among them. The remaining classes of that cycle go to the next-error vector. At most one first-error bit is ever set.
- R5: An accepted error of class c while some first-error bit is set sets next-error bit c, and the first-error vector does not change.
- R6: `irq` is high exactly while any first-error or next-error bit is set, so it rises one cycle after the error pulse that caused it.
- R7: A write through `cap_wr_en[c]` loads bit 7 of the capture register from `cap_wr_data[7]`. While bit 7 is set, an error of class c stores no tag, sets no status bit, does not claim first-error priority and raises no interrupt. `retire_now[c]` is high in the same cycle as the pulse.
- R8: A write with `cap_wr_data[6]` = 1 clears bits [6:0] of the addressed capture register. A one on `ferr_clr[c]` or `nerr_clr[c]` clears that status bit. Clears take effect before errors of the same cycle, so such an error is judged against the cleared state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| err_pulse | input | NUM_CLASSES | One-cycle error pulse per class |
| err_tag | input | NUM_CLASSES*6 | Tag of the transaction in error, slice c for class c |
| cap_wr_en | input | NUM_CLASSES | Write strobe for capture register c |
| cap_wr_data | input | 8 | Write data: bit 7 suppression, bit 6 write-one-to-clear |
| ferr_clr | input | NUM_CLASSES | Write-one-to-clear for first-error bits |
| nerr_clr | input | NUM_CLASSES | Write-one-to-clear for next-error bits |
| cap_q | output | NUM_CLASSES*8 | Capture registers, byte c for class c |
| ferr_q | output | NUM_CLASSES | First-error status vector |
| nerr_q | output | NUM_CLASSES | Next-error status vector |
| irq | output | 1 | Level interrupt |
| retire_now | output | NUM_CLASSES | Immediate retire request for a suppressed class |

## Verification
The assertions assume that error pulses, tags, writes and clears change only between clock edges and are free of X once reset is released. They also assume a status bit can change only through the block's own pulse and clear inputs. The stimulus drives every input on the falling edge. It mixes random error, write and clear traffic from a seeded generator, including cycles with several classes failing at once, with directed sequences for suppression, simultaneous clear-and-set and priority.

// File: rtl/err_log_pkg.sv
package err_log_pkg;
  localparam int TAG_W   = 6;
  localparam int REG_W   = 8;
  localparam int DIS_BIT = 7;
  localparam int VLD_BIT = 6;

  typedef struct packed {
    logic             dis;
    logic             vld;
    logic [TAG_W-1:0] tag;
  } cap_reg_t;
endpackage

// File: rtl/err_log_rst_sync.sv
module err_log_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/err_cap_reg.sv
module err_cap_reg
  import err_log_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             err,
  input  logic [TAG_W-1:0] tag_in,
  input  logic             wr_en,
  input  logic             wr_dis,
  input  logic             wr_clr,
  output cap_reg_t         reg_q,
  output logic             accept,
  output logic             retire
);
  cap_reg_t reg_d;
  logic     vld_keep;
  logic     clr_hit;
  logic     reg_en;

  always_comb begin
    clr_hit  = wr_en & wr_clr;
    vld_keep = reg_q.vld & ~clr_hit;
    accept   = err & ~reg_q.dis;
    retire   = err & reg_q.dis;
    reg_en   = wr_en | accept;

    reg_d.dis = wr_en ? wr_dis : reg_q.dis;
    reg_d.vld = vld_keep | accept;
    if (vld_keep)    reg_d.tag = reg_q.tag;
    else if (accept) reg_d.tag = tag_in;
    else             reg_d.tag = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_q <= '0;
    else if (reg_en) reg_q <= reg_d;
  end
endmodule

// File: rtl/err_first_next.sv
module err_first_next #(
  parameter int NUM_CLASSES = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_CLASSES-1:0] acc,
  input  logic [NUM_CLASSES-1:0] ferr_clr,
  input  logic [NUM_CLASSES-1:0] nerr_clr,
  output logic [NUM_CLASSES-1:0] ferr_q,
  output logic [NUM_CLASSES-1:0] nerr_q,
  output logic                   irq
);
  localparam int NC = NUM_CLASSES;

  logic [NC-1:0] ferr_keep;
  logic [NC-1:0] nerr_keep;
  logic [NC-1:0] first_pick;
  logic [NC-1:0] ferr_d;
  logic [NC-1:0] nerr_d;
  logic          found;
  logic          upd_en;

  always_comb begin
    ferr_keep  = ferr_q & ~ferr_clr;
    nerr_keep  = nerr_q & ~nerr_clr;
    first_pick = '0;
    found      = 1'b0;
    for (int k = 0; k < NC; k++) begin
      if (acc[k] && !found) begin
        first_pick[k] = 1'b1;
        found         = 1'b1;
      end
    end
    if (ferr_keep == '0) begin
      ferr_d = first_pick;
      nerr_d = nerr_keep | (acc & ~first_pick);
    end else begin
      ferr_d = ferr_keep;
      nerr_d = nerr_keep | acc;
    end
    upd_en = (|acc) | (|ferr_clr) | (|nerr_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ferr_q <= '0;
      nerr_q <= '0;
    end else if (upd_en) begin
      ferr_q <= ferr_d;
      nerr_q <= nerr_d;
    end
  end

  assign irq = (|ferr_q) | (|nerr_q);
endmodule

// File: rtl/err_first_log.sv
module err_first_log
  import err_log_pkg::*;
#(
  parameter int NUM_CLASSES = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_CLASSES-1:0]       err_pulse,
  input  logic [NUM_CLASSES*TAG_W-1:0] err_tag,
  input  logic [NUM_CLASSES-1:0]       cap_wr_en,
  input  logic [REG_W-1:0]             cap_wr_data,
  input  logic [NUM_CLASSES-1:0]       ferr_clr,
  input  logic [NUM_CLASSES-1:0]       nerr_clr,
  output logic [NUM_CLASSES*REG_W-1:0] cap_q,
  output logic [NUM_CLASSES-1:0]       ferr_q,
  output logic [NUM_CLASSES-1:0]       nerr_q,
  output logic                         irq,
  output logic [NUM_CLASSES-1:0]       retire_now
);
  localparam int NC = NUM_CLASSES;

  logic          rst_sync_n;
  logic [NC-1:0] acc;
  logic          unused_wr_bits;

  assign unused_wr_bits = ^cap_wr_data[TAG_W-1:0];

  err_log_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar c = 0; c < NC; c++) begin : g_cls
    cap_reg_t reg_q;

    err_cap_reg u_cap (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .err    (err_pulse[c]),
      .tag_in (err_tag[c*TAG_W +: TAG_W]),
      .wr_en  (cap_wr_en[c]),
      .wr_dis (cap_wr_data[DIS_BIT]),
      .wr_clr (cap_wr_data[VLD_BIT]),
      .reg_q  (reg_q),
      .accept (acc[c]),
      .retire (retire_now[c])
    );

    assign cap_q[c*REG_W +: REG_W] = reg_q;
  end

  err_first_next #(.NUM_CLASSES(NC)) u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .acc      (acc),
    .ferr_clr (ferr_clr),
    .nerr_clr (nerr_clr),
    .ferr_q   (ferr_q),
    .nerr_q   (nerr_q),
    .irq      (irq)
  );
endmodule

// File: rtl/err_first_log_chk.sv
module err_first_log_chk #(
  parameter int NUM_CLASSES = 4
) (
  input logic                     clk,
  input logic                     rst_sync_n,
  input logic [NUM_CLASSES-1:0]   err_pulse,
  input logic [NUM_CLASSES-1:0]   cap_wr_en,
  input logic [7:0]               cap_wr_data,
  input logic [NUM_CLASSES-1:0]   ferr_clr,
  input logic [NUM_CLASSES-1:0]   nerr_clr,
  input logic [NUM_CLASSES*8-1:0] cap_q,
  input logic [NUM_CLASSES-1:0]   ferr_q,
  input logic [NUM_CLASSES-1:0]   nerr_q,
  input logic                     irq
);
  logic [NUM_CLASSES-1:0] dis_vec;

  AST_FERR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_sync_n) $onehot0(ferr_q)); // R4

  AST_FERR_STICKY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((|ferr_q) && !(|(ferr_q & ferr_clr))) |=> $stable(ferr_q)); // R5

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(irq) |-> $past(|(err_pulse & ~dis_vec))); // R6

  AST_CLR_ALL_IRQ: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((&ferr_clr) && (&nerr_clr) && !(|err_pulse)) |=> !irq); // R8

  for (genvar i = 0; i < NUM_CLASSES; i++) begin : g_chk
    assign dis_vec[i] = cap_q[i*8+7];

    AST_TAG_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (cap_q[i*8+6] && !(cap_wr_en[i] && cap_wr_data[6])) |=> $stable(cap_q[i*8 +: 6])); // R3

    AST_DIS_SILENT: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (err_pulse[i] && cap_q[i*8+7] && !ferr_q[i] && !nerr_q[i] && !cap_q[i*8+6])
      |=> (!ferr_q[i] && !nerr_q[i] && !cap_q[i*8+6])); // R7
  end
endmodule

bind err_first_log err_first_log_chk #(.NUM_CLASSES(NUM_CLASSES)) u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .err_pulse   (err_pulse),
  .cap_wr_en   (cap_wr_en),
  .cap_wr_data (cap_wr_data),
  .ferr_clr    (ferr_clr),
  .nerr_clr    (nerr_clr),
  .cap_q       (cap_q),
  .ferr_q      (ferr_q),
  .nerr_q      (nerr_q),
  .irq         (irq)
);

// File: tb/err_first_log_tb.sv
module err_first_log_tb;
  localparam int NC = 4;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NC-1:0]   err_pulse;
  logic [NC*6-1:0] err_tag;
  logic [NC-1:0]   cap_wr_en;
  logic [7:0]      cap_wr_data;
  logic [NC-1:0]   ferr_clr;
  logic [NC-1:0]   nerr_clr;
  logic [NC*8-1:0] cap_q;
  logic [NC-1:0]   ferr_q;
  logic [NC-1:0]   nerr_q;
  logic            irq;
  logic [NC-1:0]   retire_now;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [7:0]    m_cap [NC];
  logic [NC-1:0] m_ferr;
  logic [NC-1:0] m_nerr;

  always #5 clk = ~clk;

  err_first_log #(.NUM_CLASSES(NC)) u_dut (
    .clk(clk), .rst_n(rst_n), .err_pulse(err_pulse), .err_tag(err_tag),
    .cap_wr_en(cap_wr_en), .cap_wr_data(cap_wr_data), .ferr_clr(ferr_clr),
    .nerr_clr(nerr_clr), .cap_q(cap_q), .ferr_q(ferr_q), .nerr_q(nerr_q),
    .irq(irq), .retire_now(retire_now)
  );

  task automatic chk(input string r, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  task automatic idle();
    err_pulse = '0; err_tag = '0; cap_wr_en = '0; cap_wr_data = '0;
    ferr_clr = '0; nerr_clr = '0;
  endtask

  function automatic logic [NC-1:0] exp_retire();
    logic [NC-1:0] r;
    for (int c = 0; c < NC; c++) r[c] = err_pulse[c] & m_cap[c][7];
    return r;
  endfunction

  // Reference model: clears first, then errors judged against cleared state.
  task automatic model_step();
    logic [NC-1:0] acc, fk, nk, pick;
    bit got;
    for (int c = 0; c < NC; c++) begin
      logic clr, vk;
      acc[c] = err_pulse[c] & ~m_cap[c][7];
      clr = cap_wr_en[c] & cap_wr_data[6];
      vk  = m_cap[c][6] & ~clr;
      if (cap_wr_en[c]) m_cap[c][7] = cap_wr_data[7];
      if (vk) ;
      else if (acc[c]) m_cap[c][5:0] = err_tag[c*6 +: 6];
      else if (clr) m_cap[c][5:0] = '0;
      m_cap[c][6] = vk | acc[c];
    end
    fk = m_ferr & ~ferr_clr;
    nk = m_nerr & ~nerr_clr;
    pick = '0; got = 0;
    for (int c = 0; c < NC; c++) if (acc[c] && !got) begin pick[c] = 1'b1; got = 1; end
    if (fk == '0) begin m_ferr = pick; m_nerr = nk | (acc & ~pick); end
    else begin m_ferr = fk; m_nerr = nk | acc; end
  endtask

  task automatic compare(input string r);
    for (int c = 0; c < NC; c++) chk(r, $sformatf("cap_q[%0d]", c), 32'(cap_q[c*8 +: 8]), 32'(m_cap[c]));
    chk(r, "ferr_q", 32'(ferr_q), 32'(m_ferr));
    chk(r, "nerr_q", 32'(nerr_q), 32'(m_nerr));
    chk(r, "irq", 32'(irq), 32'((|m_ferr) | (|m_nerr)));
  endtask

  // Inputs set by caller after a falling edge; one clock, then compare.
  task automatic tick(input string r);
    #1;
    chk(r, "retire_now", 32'(retire_now), 32'(exp_retire()));
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(r);
    idle();
  endtask

  task automatic put_err(input int c, input logic [5:0] t);
    err_pulse[c] = 1'b1;
    err_tag[c*6 +: 6] = t;
  endtask

  task automatic clear_all(input string r);
    cap_wr_en = '1; cap_wr_data = 8'h40; ferr_clr = '1; nerr_clr = '1;
    tick(r);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    idle();
    rst_n = 1'b0;
    for (int c = 0; c < NC; c++) m_cap[c] = '0;
    m_ferr = '0; m_nerr = '0;
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    compare("R1");

    // R2 R4 R6: first error from clean state
    put_err(1, 6'h15); tick("R2");
    // R3 R5: same class again, tag must hold
    put_err(1, 6'h2a); tick("R3");
    // R5: another class while first is set
    put_err(2, 6'h07); tick("R5");
    idle(); tick("R6");
    clear_all("R8");
    // R4: simultaneous errors, lowest class wins
    put_err(0, 6'h01); put_err(2, 6'h02); put_err(3, 6'h03); tick("R4");
    clear_all("R8");
    // R7: suppress class 1
    cap_wr_en[1] = 1'b1; cap_wr_data = 8'h80; tick("R7");
    put_err(1, 6'h3f); tick("R7");
    idle(); tick("R7");
    // R7: suppressed class does not take first priority
    put_err(1, 6'h11); put_err(3, 6'h22); tick("R7");
    // R8: clear and new error in same cycle
    ferr_clr[3] = 1'b1; put_err(0, 6'h0c); tick("R8");
    // R8: clear of capture register and re-error same cycle
    cap_wr_en[0] = 1'b1; cap_wr_data = 8'h40; put_err(0, 6'h33); tick("R8");
    clear_all("R8");
    cap_wr_en = '1; cap_wr_data = 8'h00; tick("R7");

    for (int n = 0; n < 400; n++) begin
      for (int c = 0; c < NC; c++) begin
        if ($urandom_range(3) == 0) put_err(c, 6'($urandom));
        if ($urandom_range(15) == 0) cap_wr_en[c] = 1'b1;
        if ($urandom_range(11) == 0) ferr_clr[c] = 1'b1;
        if ($urandom_range(11) == 0) nerr_clr[c] = 1'b1;
      end
      cap_wr_data = {($urandom_range(3) == 0), 1'($urandom), 6'($urandom)};
      tick("R5");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule